// File: doc/BRIEF.md
# Two-Speed Clock Start-Up Controller

This block chooses which clock source drives the processor core and its peripherals, and it sequences the start-up of an external crystal. The source is one of three: the primary source set by the configured oscillator mode, a low-power secondary oscillator, or the internal oscillator. Software picks a source through a two-bit select field. The block turns that field, together with the start-up state, into a registered select code for an external glitch-free clock multiplexer.

For crystal modes, a start-up timer counts external oscillations before the crystal is trusted. These oscillations arrive as single-cycle strobes in the reference clock domain. When two-speed start-up applies, the core runs from the internal oscillator while the timer counts, and the block then moves to the crystal on its own. This automatic handover never writes the software select field. Software reads a start-up-done bit to learn which source is actually active.

A sequence begins at the first power-on-reset-done pulse and again at every wake-up from sleep. A sleep request stops any sequence in progress.

Top module: `clk_start_ctrl`

## Requirements
- R1: Select field codes: 00 selects the primary source, 01 the secondary oscillator, 10 or 11 the internal oscillator. Output codes on `clk_sel`: 00 primary, 01 secondary, 10 internal. A new field value reaches `clk_sel` on the second rising edge after the write strobe.
- R2: After reset, the select field is 00, `startup_done` is 0, `ost_count` is 0 and `clk_sel` is 10.
- R3: Oscillator modes 0, 1 and 2 are crystal modes. During a crystal sequence the counter adds one per `xtal_pulse`. `startup_done` rises in the same cycle in which `ost_count` reaches OST_LIMIT (1024).
- R4: In a non-crystal mode (3 to 7), a sequence start sets `startup_done` on the next edge and leaves `ost_count` at 0.
- R5: With two-speed enabled, field 00 and a crystal mode, `clk_sel` stays at internal while counting. It moves to primary one cycle after `startup_done` rises.
- R6: With two-speed disabled in a crystal mode, `clk_sel` points at primary while the timer counts, and `startup_done` still waits for the full count.
- R7: A sequence starts on `por_done` only before the first sequence, and on `wake_pulse` only while asleep. Each start clears the counter and `startup_done`.
- R8: A `sleep_req` while counting or running clears `ost_count` and `startup_done` on the next edge. No pulses are counted until a wake-up.
- R9: The select field changes only on a software write. The automatic handover never alters it.
- R10: While the field is 01 and `sec_ready` is low, `clk_sel` keeps its previous value. It switches to secondary once `sec_ready` is high.
- R11: `ost_count` saturates at OST_LIMIT. Further pulses do not change it.
- R12: After `clk_sel` changes, it holds its new value for at least HOLD_CYCLES (1) further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_wr_en | input | 1 | Software write strobe for the select field |
| sel_wr_data | input | 2 | Select field value to write |
| osc_mode | input | 3 | Configured primary oscillator mode (0 to 2 are crystal modes) |
| two_speed_en | input | 1 | Two-speed start-up enable |
| por_done | input | 1 | Pulse at the end of the power-up delay |
| wake_pulse | input | 1 | Pulse on wake-up from sleep |
| sleep_req | input | 1 | Pulse on entry to sleep |
| sec_ready | input | 1 | Secondary oscillator ready flag |
| xtal_pulse | input | 1 | Synchronized single-cycle strobe per crystal oscillation |
| sel_field | output | 2 | Current software select field |
| clk_sel | output | 2 | Select code for the clock multiplexer |
| startup_done | output | 1 | Start-up timer has completed |
| ost_count | output | CNT_W (11) | Start-up oscillation count |

## Verification
If the sequencer state is wrong, the effect reaches the ports within one edge. `startup_done` or `ost_count` takes the wrong value, or the counter keeps moving while asleep. A wrong hold counter or wrong select logic shows on `clk_sel` one or two edges after the causing input: it switches too early, too late, or twice in a row. A reference model runs alongside the design and compares all four outputs every cycle. Any divergence is therefore reported in the first cycle it becomes visible.

// File: rtl/clk_start_pkg.sv
package clk_start_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_COUNT = 2'd1,
    SEQ_RUN   = 2'd2,
    SEQ_SLEEP = 2'd3
  } seq_state_e;

  localparam int MODE_W        = 3;
  localparam int CRYSTAL_MODES = 3;

  localparam logic [1:0] SRC_PRIMARY   = 2'b00;
  localparam logic [1:0] SRC_SECONDARY = 2'b01;
  localparam logic [1:0] SRC_INTERNAL  = 2'b10;

  localparam logic [1:0] FIELD_SECONDARY = 2'b01;

  function automatic logic mode_is_crystal(input logic [MODE_W-1:0] m);
    return (int'(m) < CRYSTAL_MODES);
  endfunction

endpackage

// File: rtl/cs_ost_counter.sv
module cs_ost_counter #(
  parameter int LIMIT = 1024,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          phase,
  input  logic          xtal_pulse,
  output logic [CW-1:0] count,
  output logic          last_pulse
);

  localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic step;

  // count only below the ceiling, so the value saturates at LIMIT
  assign step       = phase & xtal_pulse & (count < LIM_V);
  assign last_pulse = step & (count == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (clr)  count <= '0;
    else if (step) count <= count + 1'b1;
  end

  p_count_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM_V);

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(phase && xtal_pulse)) |=> $stable(count));

endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import clk_start_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_done,
  input  logic       wake_pulse,
  input  logic       sleep_req,
  input  logic       crystal,
  input  logic       last_pulse,
  output seq_state_e state,
  output logic       done,
  output logic       cnt_clr,
  output logic       count_phase
);

  seq_state_e state_d;
  logic       done_d;
  logic       start;
  logic       go_sleep;

  always_comb begin
    start    = ((state == SEQ_IDLE) && por_done) ||
               ((state == SEQ_SLEEP) && wake_pulse);
    go_sleep = sleep_req && ((state == SEQ_COUNT) || (state == SEQ_RUN));
    state_d  = state;
    done_d   = done;
    if (go_sleep) begin
      state_d = SEQ_SLEEP;
      done_d  = 1'b0;
    end else if (start) begin
      state_d = crystal ? SEQ_COUNT : SEQ_RUN;
      done_d  = !crystal;
    end else if ((state == SEQ_COUNT) && (!crystal || last_pulse)) begin
      state_d = SEQ_RUN;
      done_d  = 1'b1;
    end
    cnt_clr     = go_sleep || start;
    count_phase = (state == SEQ_COUNT) && crystal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_d;
      done  <= done_d;
    end
  end

  p_sleep_drops_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && ((state == SEQ_COUNT) || (state == SEQ_RUN)))
      |=> (!done && (state == SEQ_SLEEP)));

  p_wake_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_SLEEP) && wake_pulse && crystal)
      |=> ((state == SEQ_COUNT) && !done));

  p_asleep_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == SEQ_SLEEP) && !wake_pulse) |=> ((state == SEQ_SLEEP) && !done));

endmodule

// File: rtl/cs_src_select.sv
module cs_src_select
  import clk_start_pkg::*;
#(
  parameter int HOLD_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] field,
  input  logic       sec_ready,
  input  logic       primary_ok,
  output logic [1:0] sel
);

  logic [1:0] want;
  logic       hold_busy;
  logic       change;

  always_comb begin
    if (field[1])      want = SRC_INTERNAL;
    else if (field[0]) want = sec_ready ? SRC_SECONDARY : sel;
    else               want = primary_ok ? SRC_PRIMARY : SRC_INTERNAL;
  end

  assign change = (want != sel) && !hold_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel <= SRC_INTERNAL;
    else if (change) sel <= want;
  end

  generate
    if (HOLD_CYCLES > 0) begin : g_hold
      localparam int HW = $clog2(HOLD_CYCLES + 1);
      logic [HW-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              hold_q <= '0;
        else if (change)         hold_q <= HW'(HOLD_CYCLES);
        else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
      end

      assign hold_busy = (hold_q != '0);

      p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |=> $stable(sel));
    end else begin : g_nohold
      assign hold_busy = 1'b0;
    end
  endgenerate

  p_sec_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((field == FIELD_SECONDARY) && !sec_ready) |=> $stable(sel));

  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'b11);

endmodule

// File: rtl/clk_start_ctrl.sv
module clk_start_ctrl
  import clk_start_pkg::*;
#(
  parameter int OST_LIMIT   = 1024,
  parameter int HOLD_CYCLES = 1,
  localparam int CNT_W = $clog2(OST_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr_en,
  input  logic [1:0]        sel_wr_data,
  input  logic [MODE_W-1:0] osc_mode,
  input  logic              two_speed_en,
  input  logic              por_done,
  input  logic              wake_pulse,
  input  logic              sleep_req,
  input  logic              sec_ready,
  input  logic              xtal_pulse,
  output logic [1:0]        sel_field,
  output logic [1:0]        clk_sel,
  output logic              startup_done,
  output logic [CNT_W-1:0]  ost_count
);

  seq_state_e seq_state;
  logic       crystal;
  logic       primary_ok;
  logic       cnt_clr;
  logic       count_phase;
  logic       last_pulse;

  assign crystal = mode_is_crystal(osc_mode);

  // primary is usable when start-up is complete or no two-speed wait applies
  assign primary_ok = startup_done || !(crystal && two_speed_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_field <= 2'b00;
    else if (sel_wr_en) sel_field <= sel_wr_data;
  end

  cs_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_done    (por_done),
    .wake_pulse  (wake_pulse),
    .sleep_req   (sleep_req),
    .crystal     (crystal),
    .last_pulse  (last_pulse),
    .state       (seq_state),
    .done        (startup_done),
    .cnt_clr     (cnt_clr),
    .count_phase (count_phase)
  );

  cs_ost_counter #(.LIMIT(OST_LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cnt_clr),
    .phase      (count_phase),
    .xtal_pulse (xtal_pulse),
    .count      (ost_count),
    .last_pulse (last_pulse)
  );

  cs_src_select #(.HOLD_CYCLES(HOLD_CYCLES)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .field      (sel_field),
    .sec_ready  (sec_ready),
    .primary_ok (primary_ok),
    .sel        (clk_sel)
  );

  p_field_auto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_en |=> $stable(sel_field));

  p_noncrystal_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((seq_state == SEQ_SLEEP) && wake_pulse && !crystal)
      |=> (startup_done && (ost_count == '0)));

endmodule

// File: tb/clk_start_ctrl_tb_top.sv
`timescale 1ns/1ps
module clk_start_ctrl_tb_top;

  localparam int LIM = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr;
  logic [1:0]  wdata;
  logic [2:0]  mode;
  logic        tsu, por, wake, slp, sec, xp;
  logic [1:0]  sel_field, clk_sel;
  logic        startup_done;
  logic [10:0] ost_count;

  always #2.5 clk = ~clk;

  clk_start_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(wr), .sel_wr_data(wdata),
    .osc_mode(mode), .two_speed_en(tsu), .por_done(por), .wake_pulse(wake),
    .sleep_req(slp), .sec_ready(sec), .xtal_pulse(xp),
    .sel_field(sel_field), .clk_sel(clk_sel), .startup_done(startup_done),
    .ost_count(ost_count)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state: 0 idle, 1 counting, 2 running, 3 asleep
  int         m_st, m_cnt, m_hold;
  bit         m_done;
  logic [1:0] m_sel, m_field, prev_sel;
  bit         prev_changed;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input logic [1:0] f, input bit s,
                                         input bit pok, input logic [1:0] cur);
    if (f[1])      return 2'b10;
    else if (f[0]) return s ? 2'b01 : cur;
    else           return pok ? 2'b00 : 2'b10;
  endfunction

  task automatic model_step();
    bit cry, pok, start;
    logic [1:0] w;
    cry = (mode < 3);
    pok = m_done || !(cry && tsu);
    if (m_hold > 0) m_hold--;
    else begin
      w = exp_sel(m_field, sec, pok, m_sel);
      if (w != m_sel) begin m_sel = w; m_hold = 1; end
    end
    start = (m_st == 0 && por) || (m_st == 3 && wake);
    if (slp && (m_st == 1 || m_st == 2)) begin
      m_st = 3; m_done = 0; m_cnt = 0;
    end else if (start) begin
      m_cnt = 0;
      if (cry) begin m_st = 1; m_done = 0; end
      else     begin m_st = 2; m_done = 1; end
    end else if (m_st == 1) begin
      if (!cry) begin m_st = 2; m_done = 1; end
      else if (xp && m_cnt < LIM) begin
        m_cnt++;
        if (m_cnt == LIM) begin m_st = 2; m_done = 1; end
      end
    end
    if (wr) m_field = wdata;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R3", "ost_count", int'(ost_count), m_cnt);
    chk("R3", "startup_done", int'(startup_done), int'(m_done));
    chk("R1", "clk_sel", int'(clk_sel), int'(m_sel));
    chk("R9", "sel_field", int'(sel_field), int'(m_field));
    if (prev_changed) chk("R12", "clk_sel hold", int'(clk_sel), int'(prev_sel));
    prev_changed = (clk_sel != prev_sel);
    prev_sel = clk_sel;
    wr = 0; por = 0; wake = 0; slp = 0; xp = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin xp = 1; tick(); end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr = 0; wdata = 0; mode = 3'd2; tsu = 1;
    por = 0; wake = 0; slp = 0; sec = 0; xp = 0;
    m_st = 0; m_cnt = 0; m_hold = 0; m_done = 0; m_sel = 2'b10; m_field = 2'b00;
    prev_sel = 2'b10; prev_changed = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    chk("R2", "sel_field", int'(sel_field), 0);
    chk("R2", "startup_done", int'(startup_done), 0);
    chk("R2", "ost_count", int'(ost_count), 0);
    chk("R2", "clk_sel", int'(clk_sel), 2);

    // two-speed start-up after power-on, HS crystal
    por = 1; tick();
    pulses(LIM - 1);
    chk("R5", "clk_sel while counting", int'(clk_sel), 2);
    chk("R3", "count before last pulse", int'(ost_count), LIM - 1);
    chk("R3", "done before last pulse", int'(startup_done), 0);
    pulses(1);
    chk("R3", "done at limit", int'(startup_done), 1);
    chk("R3", "count at limit", int'(ost_count), LIM);
    tick();
    chk("R5", "clk_sel after handover", int'(clk_sel), 0);
    chk("R9", "field after handover", int'(sel_field), 0);
    pulses(5);
    chk("R11", "count saturated", int'(ost_count), LIM);
    por = 1; tick();
    chk("R7", "por ignored once running", int'(startup_done), 1);

    // sleep and wake handling
    slp = 1; tick();
    chk("R8", "done after sleep", int'(startup_done), 0);
    chk("R8", "count after sleep", int'(ost_count), 0);
    pulses(10);
    chk("R8", "no counting asleep", int'(ost_count), 0);
    wake = 1; tick();
    chk("R7", "count on wake", int'(ost_count), 0);
    chk("R7", "done on wake", int'(startup_done), 0);
    pulses(300);
    chk("R7", "counting after wake", int'(ost_count), 300);
    slp = 1; xp = 1; tick();
    chk("R8", "abort count", int'(ost_count), 0);
    chk("R8", "abort done", int'(startup_done), 0);
    wake = 1; tick();

    // two-speed disabled: primary selected during the wait
    tsu = 0; tick(); tick(); tick();
    chk("R6", "clk_sel primary while counting", int'(clk_sel), 0);
    chk("R6", "done still low", int'(startup_done), 0);
    pulses(LIM);
    chk("R6", "done after full count", int'(startup_done), 1);

    // non-crystal mode
    mode = 3'd3; tsu = 1;
    slp = 1; tick();
    wake = 1; tick();
    chk("R4", "done immediately", int'(startup_done), 1);
    chk("R4", "count stays zero", int'(ost_count), 0);
    tick();
    chk("R4", "clk_sel primary", int'(clk_sel), 0);

    // secondary oscillator gating and field codes
    sec = 0; wr = 1; wdata = 2'b01; tick();
    repeat (5) tick();
    chk("R10", "held while not ready", int'(clk_sel), 0);
    sec = 1; tick();
    chk("R10", "secondary once ready", int'(clk_sel), 1);
    wr = 1; wdata = 2'b10; tick(); tick();
    chk("R1", "field 10 internal", int'(clk_sel), 2);
    wr = 1; wdata = 2'b11; tick(); tick();
    chk("R1", "field 11 internal", int'(clk_sel), 2);
    wr = 1; wdata = 2'b00; tick(); tick();
    chk("R1", "field 00 primary", int'(clk_sel), 0);

    // constrained random phase against the model
    for (int i = 0; i < 40000; i++) begin
      xp   = ($urandom % 4) != 0;
      wake = ($urandom % 60) == 0;
      slp  = ($urandom % 2500) == 0;
      por  = ($urandom % 500) == 0;
      if (($urandom % 1500) == 0) mode = 3'($urandom % 8);
      if (($urandom % 3000) == 0) tsu = ~tsu;
      if (($urandom % 400) == 0)  sec = ~sec;
      if (($urandom % 300) == 0) begin wr = 1; wdata = 2'($urandom % 4); end
      tick();
    end

    summary();
    $finish;
  end

endmodule